// File: doc/BRIEF.md
# Dual-Protocol Priority Interrupt Controller with Cascading

This block collects eight level-sensitive interrupt request lines, masks each one on its own, ranks them by a fixed priority and raises a single interrupt output towards the processor. It keeps an in-service register so that a request can nest above the one being handled, while equal or lower requests wait. The host sets it up and sends end-of-interrupt commands through a small two-address register port with chip select and separate read and write strobes.

The processor answers an interrupt with a train of acknowledge pulses. The block supports two protocols for this. In call mode it supplies a three-byte subroutine call: an opcode, then the two bytes of a target address. In vector-type mode the first pulse is a dummy and the second returns a type number. Two instances can be cascaded. A master treats level 3 as the output of a slave controller. During the acknowledge it places the slave's identity on three cascade lines and leaves the vector bytes to that slave. If the request has gone away by the first pulse, the controller answers as if level 7 had been requested.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the interrupt output, bus enable and cascade enable are low. The in-service register reads 0x00. The mask reads 0xFF, so every line starts masked.
- R2: Level 0 has the highest priority and level 7 the lowest. Among the unmasked requests, the lowest-numbered line wins. A request seen at the input is reflected on the interrupt output one clock later.
- R3: Setting mask bit n blocks line n only. A blocked line never raises the interrupt output, and the other lines behave exactly as they do when it is unmasked.
- R4: The interrupt output is high only when an unmasked request has strictly higher priority than every in-service level. An equal or lower request keeps it low.
- R5: In call mode the three pulses return, in order:
  - 0xCD;
  - the low byte {low_base[7:5], level[2:0], 2'b00};
  - the programmed high byte.
- R6: In vector-type mode the first pulse leaves the bus undriven. The second returns {type_base[7:3], level[2:0]}. The bus is driven only while an acknowledge pulse is high.
- R7: A master sets the in-service bit of the winning level on the first pulse. An end-of-interrupt command (0x00 written to address 0) clears the highest-priority in-service bit.
- R8: Configuration byte 0x40 | {id[2:0], cascade, master, call} is written to address 0, with bit 0 = call, bit 1 = master and bit 2 = cascade. When a master with cascade enabled grants level 3, it drives the value 3 on the cascade lines. The cascade enable is high from just after the first pulse through the last pulse. The master leaves the bus undriven on the pulses that carry vector bytes.
- R9: A slave drives the vector bytes, and sets its in-service bit, only on pulses where the cascade input equals its programmed id. It never drives on the first pulse.
- R10: If no request is granted at the first pulse, the controller answers with level-7 bytes and sets no in-service bit.
- R11: Until a configuration byte has been written, acknowledge pulses are ignored. Nothing is driven and no in-service bit is set.
- R12: Register access is as follows:
  - A write takes effect only while chip select is high.
  - Address 0 accepts commands: 0x00 is end-of-interrupt, 0x40|cfg is configure, and 0x80|sel selects a register (0 mask, 1 low base, 2 high byte, 3 type base).
  - Address 1 writes the selected register and reads it back.
  - A read of address 0 returns the in-service register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 8 | Level-sensitive request lines, bit 0 highest priority |
| cs_i | input | 1 | Register port chip select |
| addr_i | input | 1 | Register port address: 0 command/status, 1 data |
| wr_i | input | 1 | Register write strobe, one clock per write |
| rd_i | input | 1 | Register read strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data, zero when not reading |
| ack_i | input | 1 | Interrupt-acknowledge pulse, one clock wide |
| cas_i | input | 3 | Cascade identity seen by a slave |
| irq_o | output | 1 | Interrupt request to the processor |
| bus_o | output | 8 | Acknowledge response byte |
| bus_oe_o | output | 1 | Response byte is being driven |
| cas_o | output | 3 | Cascade identity driven by a master |
| cas_oe_o | output | 1 | Cascade lines are being driven |

## Verification
The bound checker watches several properties on every clock:
- a masked or absent request never raises the interrupt output;
- in-service bits appear at most one per clock, and only after an acknowledge pulse;
- the bus is driven only inside an acknowledge pulse, and never while the cascade lines are driven;
- an unconfigured controller stays silent.

Other behaviour needs the bench's scenarios, where a master and a slave share one bus:
- the byte values for each protocol;
- nesting and end-of-interrupt ordering;
- the level-7 fallback;
- the handover of the bus to the slave selected by the cascade lines.

// File: rtl/ipc_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the priority interrupt controller.
// Assumes eight levels (three level bits) and an eight-bit data path.
package ipc_pkg;
    localparam int LVL_W = 3;
    localparam logic [7:0] CALL_OPCODE = 8'hCD;

    // Command class carried in bits 7:6 of an address-0 write.
    typedef enum logic [1:0] {
        CMD_EOI  = 2'b00,
        CMD_CFG  = 2'b01,
        CMD_SEL  = 2'b10,
        CMD_NONE = 2'b11
    } cmd_e;

    // Register reached through address 1.
    typedef enum logic [1:0] {
        SEL_MASK = 2'd0,
        SEL_LOW  = 2'd1,
        SEL_HIGH = 2'd2,
        SEL_TYPE = 2'd3
    } sel_e;

    // Operating configuration; packed so that wdata[5:0] maps straight in.
    typedef struct packed {
        logic [LVL_W-1:0] id;
        logic             casc;
        logic             master;
        logic             call;
    } cfg_t;
endpackage

// File: rtl/ipc_regs.sv
`timescale 1ns/1ps
// Host register port: decodes commands, holds the mask, the vector
// bases and the configuration, and drives read data.
// Assumes single-cycle write strobes synchronous to clk.
module ipc_regs
    import ipc_pkg::*;
#(
    parameter int DW = 8,
    parameter int NL = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_i,
    input  logic          addr_i,
    input  logic          wr_i,
    input  logic          rd_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [NL-1:0] isr_i,
    output logic [DW-1:0] rdata_o,
    output cfg_t          cfg_o,
    output logic          cfg_valid_o,
    output logic          cfg_wr_o,
    output logic          eoi_o,
    output logic [NL-1:0] mask_o,
    output logic [DW-1:0] low_base_o,
    output logic [DW-1:0] high_byte_o,
    output logic [DW-1:0] type_base_o
);
    sel_e sel_q;
    cmd_e cmd;
    logic cmd_wr;
    logic data_wr;

    // Decode which kind of write happens this cycle.
    always_comb begin
        cmd      = cmd_e'(wdata_i[DW-1:DW-2]);
        cmd_wr   = cs_i && wr_i && !addr_i;
        data_wr  = cs_i && wr_i && addr_i;
        eoi_o    = cmd_wr && (cmd == CMD_EOI);
        cfg_wr_o = cmd_wr && (cmd == CMD_CFG);
    end

    // Register updates from host writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o       <= '0;
            cfg_valid_o <= 1'b0;
            sel_q       <= SEL_MASK;
            mask_o      <= '1;
            low_base_o  <= '0;
            high_byte_o <= '0;
            type_base_o <= '0;
        end else if (cmd_wr) begin
            case (cmd)
                CMD_CFG: begin
                    cfg_o       <= cfg_t'(wdata_i[$bits(cfg_t)-1:0]);
                    cfg_valid_o <= 1'b1;
                end
                CMD_SEL: sel_q <= sel_e'(wdata_i[1:0]);
                default: ;
            endcase
        end else if (data_wr) begin
            case (sel_q)
                SEL_MASK: mask_o      <= wdata_i[NL-1:0];
                SEL_LOW:  low_base_o  <= wdata_i;
                SEL_HIGH: high_byte_o <= wdata_i;
                default:  type_base_o <= wdata_i;
            endcase
        end
    end

    // Read data: in-service at address 0, selected register at address 1.
    always_comb begin
        rdata_o = '0;
        if (cs_i && rd_i) begin
            if (!addr_i) begin
                rdata_o = DW'(isr_i);
            end else begin
                case (sel_q)
                    SEL_MASK: rdata_o = DW'(mask_o);
                    SEL_LOW:  rdata_o = low_base_o;
                    SEL_HIGH: rdata_o = high_byte_o;
                    default:  rdata_o = type_base_o;
                endcase
            end
        end
    end
endmodule

// File: rtl/ipc_resolve.sv
`timescale 1ns/1ps
// Priority resolver and in-service register. Samples the request lines
// once per clock, picks the lowest-numbered unmasked request and grants
// it only above every in-service level.
// Assumes NL = 2**LVL_W.
module ipc_resolve
    import ipc_pkg::*;
#(
    parameter int NL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NL-1:0]    req_i,
    input  logic [NL-1:0]    mask_i,
    input  logic             eoi_i,
    input  logic             set_i,
    input  logic [LVL_W-1:0] set_lvl_i,
    output logic             grant_o,
    output logic [LVL_W-1:0] win_o,
    output logic [NL-1:0]    isr_o
);
    logic [NL-1:0]    req_q;
    logic [NL-1:0]    pend;
    logic             any_pend;
    logic [LVL_W-1:0] top_isr;
    logic             busy;
    logic [NL-1:0]    isr_nxt;

    // Sample the request lines on the system clock.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req_i;
    end

    // Find the highest-priority pending request and in-service level.
    always_comb begin
        pend     = req_q & ~mask_i;
        win_o    = '0;
        any_pend = 1'b0;
        top_isr  = '0;
        busy     = 1'b0;
        for (int i = NL - 1; i >= 0; i--) begin
            if (pend[i]) begin
                win_o    = LVL_W'(i);
                any_pend = 1'b1;
            end
            if (isr_o[i]) begin
                top_isr = LVL_W'(i);
                busy    = 1'b1;
            end
        end
        grant_o = any_pend && (!busy || (win_o < top_isr));
    end

    // Next in-service value: end-of-interrupt clears, acknowledge sets.
    always_comb begin
        isr_nxt = isr_o;
        if (eoi_i && busy) isr_nxt[top_isr] = 1'b0;
        if (set_i)         isr_nxt[set_lvl_i] = 1'b1;
    end

    // In-service register.
    always_ff @(posedge clk) begin
        if (!rst_n) isr_o <= '0;
        else        isr_o <= isr_nxt;
    end
endmodule

// File: rtl/ipc_ack_seq.sv
`timescale 1ns/1ps
// Acknowledge sequencer: counts acknowledge pulses, latches the answered
// level, builds the response bytes for call or vector-type mode and
// drives or follows the cascade lines.
// Assumes ack_i is one clock wide and the mode is fixed while a
// sequence runs (a configuration write restarts the count).
module ipc_ack_seq
    import ipc_pkg::*;
#(
    parameter int DW         = 8,
    parameter int NL         = 8,
    parameter int CASC_LEVEL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_i,
    input  cfg_t             cfg_i,
    input  logic             cfg_valid_i,
    input  logic             cfg_wr_i,
    input  logic             grant_i,
    input  logic [LVL_W-1:0] win_i,
    input  logic [DW-1:0]    low_base_i,
    input  logic [DW-1:0]    high_byte_i,
    input  logic [DW-1:0]    type_base_i,
    input  logic [LVL_W-1:0] cas_i,
    output logic             set_o,
    output logic [LVL_W-1:0] set_lvl_o,
    output logic [DW-1:0]    bus_o,
    output logic             bus_oe_o,
    output logic [LVL_W-1:0] cas_o,
    output logic             cas_oe_o
);
    localparam logic [LVL_W-1:0] SPURIOUS = LVL_W'(NL - 1);
    localparam logic [LVL_W-1:0] CASC_LVL = LVL_W'(CASC_LEVEL);

    logic [1:0]       cnt_q;
    logic [LVL_W-1:0] lvl_q;
    logic             gnt_q;
    logic [1:0]       last;
    logic             take;
    logic             casc_hit;
    logic             sel_hit;
    logic             drive;
    logic [DW-1:0]    byte_val;

    // Qualify pulses and decode the cascade role.
    always_comb begin
        last     = cfg_i.call ? 2'd2 : 2'd1;
        take     = ack_i && cfg_valid_i;
        casc_hit = cfg_i.master && cfg_i.casc && (lvl_q == CASC_LVL);
        sel_hit  = (cas_i == cfg_i.id);
    end

    // Pulse counter and level latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= '0;
            gnt_q <= 1'b0;
        end else if (cfg_wr_i) begin
            cnt_q <= '0;
        end else if (take) begin
            if (cnt_q == 2'd0) begin
                lvl_q <= grant_i ? win_i : SPURIOUS;
                gnt_q <= grant_i;
            end
            cnt_q <= (cnt_q == last) ? 2'd0 : cnt_q + 2'd1;
        end
    end

    // In-service set: master on the first pulse, slave when selected.
    always_comb begin
        if (cfg_i.master) begin
            set_o     = take && (cnt_q == 2'd0) && grant_i;
            set_lvl_o = win_i;
        end else begin
            set_o     = take && (cnt_q == 2'd1) && gnt_q && sel_hit;
            set_lvl_o = lvl_q;
        end
    end

    // Response byte for the current pulse.
    always_comb begin
        if (cnt_q == 2'd0)
            byte_val = CALL_OPCODE;
        else if (cnt_q == 2'd1)
            byte_val = cfg_i.call ? {low_base_i[DW-1:LVL_W+2], lvl_q, 2'b00}
                                  : {type_base_i[DW-1:LVL_W], lvl_q};
        else
            byte_val = high_byte_i;
    end

    // Decide who drives the bus on this pulse.
    always_comb begin
        if (!take)
            drive = 1'b0;
        else if (cnt_q == 2'd0)
            drive = cfg_i.master && cfg_i.call;
        else if (cfg_i.master)
            drive = !casc_hit;
        else
            drive = sel_hit;
        bus_oe_o = drive;
        bus_o    = drive ? byte_val : '0;
    end

    // Cascade lines held from the first pulse through the last.
    always_comb begin
        cas_oe_o = cfg_valid_i && (cnt_q != 2'd0) && casc_hit;
        cas_o    = cas_oe_o ? lvl_q : '0;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
`timescale 1ns/1ps
// Top of the eight-level priority interrupt controller. Ties the host
// register port, the priority resolver and the acknowledge sequencer.
// Assumes all inputs are synchronous to clk.
module irq_prio_ctrl
    import ipc_pkg::*;
#(
    parameter int DW         = 8,
    parameter int CASC_LEVEL = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       req_i,
    input  logic             cs_i,
    input  logic             addr_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    input  logic             ack_i,
    input  logic [2:0]       cas_i,
    output logic             irq_o,
    output logic [DW-1:0]    bus_o,
    output logic             bus_oe_o,
    output logic [2:0]       cas_o,
    output logic             cas_oe_o
);
    localparam int NL = 1 << LVL_W;

    cfg_t             cfg_w;
    logic             cfg_valid_w;
    logic             cfg_wr_w;
    logic             eoi_w;
    logic [NL-1:0]    mask_w;
    logic [DW-1:0]    low_base_w;
    logic [DW-1:0]    high_byte_w;
    logic [DW-1:0]    type_base_w;
    logic [NL-1:0]    isr_w;
    logic             grant_w;
    logic [LVL_W-1:0] win_w;
    logic             set_w;
    logic [LVL_W-1:0] set_lvl_w;

    ipc_regs #(.DW(DW), .NL(NL)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_i        (cs_i),
        .addr_i      (addr_i),
        .wr_i        (wr_i),
        .rd_i        (rd_i),
        .wdata_i     (wdata_i),
        .isr_i       (isr_w),
        .rdata_o     (rdata_o),
        .cfg_o       (cfg_w),
        .cfg_valid_o (cfg_valid_w),
        .cfg_wr_o    (cfg_wr_w),
        .eoi_o       (eoi_w),
        .mask_o      (mask_w),
        .low_base_o  (low_base_w),
        .high_byte_o (high_byte_w),
        .type_base_o (type_base_w)
    );

    ipc_resolve #(.NL(NL)) u_resolve (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req_i),
        .mask_i    (mask_w),
        .eoi_i     (eoi_w),
        .set_i     (set_w),
        .set_lvl_i (set_lvl_w),
        .grant_o   (grant_w),
        .win_o     (win_w),
        .isr_o     (isr_w)
    );

    ipc_ack_seq #(.DW(DW), .NL(NL), .CASC_LEVEL(CASC_LEVEL)) u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_i       (ack_i),
        .cfg_i       (cfg_w),
        .cfg_valid_i (cfg_valid_w),
        .cfg_wr_i    (cfg_wr_w),
        .grant_i     (grant_w),
        .win_i       (win_w),
        .low_base_i  (low_base_w),
        .high_byte_i (high_byte_w),
        .type_base_i (type_base_w),
        .cas_i       (cas_i),
        .set_o       (set_w),
        .set_lvl_o   (set_lvl_w),
        .bus_o       (bus_o),
        .bus_oe_o    (bus_oe_o),
        .cas_o       (cas_o),
        .cas_oe_o    (cas_oe_o)
    );

    // Interrupt output follows the resolver's grant.
    assign irq_o = grant_w;
endmodule

// File: rtl/ipc_checker.sv
`timescale 1ns/1ps
// Clocked properties for irq_prio_ctrl, attached by bind below.
module ipc_checker #(
    parameter int NL = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NL-1:0] req_i,
    input logic [NL-1:0] mask,
    input logic [NL-1:0] isr,
    input logic          cfg_valid,
    input logic          ack_i,
    input logic          irq_o,
    input logic          bus_oe_o,
    input logic          cas_oe_o
);
    // R3: a masked or absent request never raises the interrupt output.
    a_r3_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(req_i) & ~mask) == '0) |-> !irq_o);

    // R2: a raised interrupt always has an unmasked request behind it.
    a_r2_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (($past(req_i) & ~mask) != '0));

    // R7: at most one in-service bit appears per clock.
    a_r7_one_set_per_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(isr & ~$past(isr)));

    // R7: a new in-service bit only follows an acknowledge pulse.
    a_r7_set_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ((isr & ~$past(isr)) != '0) |-> $past(ack_i));

    // R6: the response bus is driven only inside an acknowledge pulse.
    a_r6_drive_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> ack_i);

    // R8: a master steering the cascade lines leaves the bus to the slave.
    a_r8_cas_excludes_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cas_oe_o |-> !bus_oe_o);

    // R11: an unconfigured controller drives nothing.
    a_r11_quiet_unconfigured: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_valid |-> (!bus_oe_o && !cas_oe_o));
endmodule

bind irq_prio_ctrl ipc_checker #(.NL(NL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .mask      (mask_w),
    .isr       (isr_w),
    .cfg_valid (cfg_valid_w),
    .ack_i     (ack_i),
    .irq_o     (irq_o),
    .bus_oe_o  (bus_oe_o),
    .cas_oe_o  (cas_oe_o)
);

// File: tb/irq_prio_ctrl_test.sv
`timescale 1ns/1ps
// Scoreboard bench: a master (uut) and a slave (uut_slave) on a shared
// acknowledge bus. Driver tasks queue the expected response per pulse,
// a monitor pops and compares at the falling edge.
module irq_prio_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mreq = '0;
    logic [7:0] sreq = '0;
    logic       cs_m = 1'b0;
    logic       cs_s = 1'b0;
    logic       addr = 1'b0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic       ack = 1'b0;

    logic [7:0] m_rdata, s_rdata, m_bus, s_bus;
    logic       m_irq, s_irq, m_oe, s_oe, m_cas_oe, s_cas_oe;
    logic [2:0] m_cas, s_cas;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [8:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    irq_prio_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_i({mreq[7:4], s_irq, mreq[2:0]}),
        .cs_i(cs_m), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
        .rdata_o(m_rdata), .ack_i(ack), .cas_i(3'b000), .irq_o(m_irq),
        .bus_o(m_bus), .bus_oe_o(m_oe), .cas_o(m_cas), .cas_oe_o(m_cas_oe)
    );

    irq_prio_ctrl uut_slave (
        .clk(clk), .rst_n(rst_n), .req_i(sreq),
        .cs_i(cs_s), .addr_i(addr), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
        .rdata_o(s_rdata), .ack_i(ack), .cas_i(m_cas), .irq_o(s_irq),
        .bus_o(s_bus), .bus_oe_o(s_oe), .cas_o(s_cas), .cas_oe_o(s_cas_oe)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wreg(input bit slave, input bit a, input logic [7:0] d);
        @(posedge clk); #1;
        cs_m = !slave; cs_s = slave; addr = a; wr = 1'b1; wdata = d;
        @(posedge clk); #1;
        cs_m = 1'b0; cs_s = 1'b0; wr = 1'b0;
    endtask

    task automatic rreg(input bit slave, input bit a, output logic [7:0] d);
        @(posedge clk); #1;
        cs_m = !slave; cs_s = slave; addr = a; rd = 1'b1;
        #1 d = slave ? s_rdata : m_rdata;
        @(posedge clk); #1;
        cs_m = 1'b0; cs_s = 1'b0; rd = 1'b0;
    endtask

    // Driver: one acknowledge pulse with its expected response.
    task automatic ack_exp(input string tag, input logic oe, input logic [7:0] v);
        @(posedge clk); #1;
        exp_q.push_back({oe, oe ? v : 8'h00});
        tag_q.push_back(tag);
        ack = 1'b1;
        @(posedge clk); #1;
        ack = 1'b0;
    endtask

    // Monitor: merge both drivers and compare against the scoreboard.
    always @(negedge clk) begin
        if (ack && !done) begin
            logic [8:0] act;
            string      t;
            if (m_oe && s_oe) begin
                checks++; fails++;
                $display("FAIL R9: both drivers on bus actual m=0x%0h s=0x%0h expected one", m_bus, s_bus);
            end
            act = m_oe ? {1'b1, m_bus} : (s_oe ? {1'b1, s_bus} : 9'h000);
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R6: unexpected pulse actual 0x%0h expected none", act);
            end else begin
                t = tag_q.pop_front();
                chk(t, int'(act), int'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 irq", m_irq, 0);
        chk("R1 bus_oe", m_oe, 0);
        chk("R1 cas_oe", m_cas_oe, 0);
        rreg(0, 0, d); chk("R1 isr", d, 8'h00);
        rreg(0, 1, d); chk("R1 mask", d, 8'hFF);
        // R12 write without chip select is ignored
        @(posedge clk); #1 addr = 1'b1; wr = 1'b1; wdata = 8'h00;
        @(posedge clk); #1 wr = 1'b0;
        rreg(0, 1, d); chk("R12 no-cs write", d, 8'hFF);
        wreg(0, 1, 8'h00);
        rreg(0, 1, d); chk("R12 mask write", d, 8'h00);
        // R11 unconfigured: acks ignored
        mreq = 8'h01; settle(2);
        chk("R2 irq on level0", m_irq, 1);
        ack_exp("R11 pulse1", 0, 8'h00);
        ack_exp("R11 pulse2", 0, 8'h00);
        rreg(0, 0, d); chk("R11 isr", d, 8'h00);
        // configure master: vector mode, cascade on level 3
        wreg(0, 0, 8'h46);
        wreg(0, 0, 8'h83); wreg(0, 1, 8'hA8);
        wreg(0, 0, 8'h81); wreg(0, 1, 8'h40);
        wreg(0, 0, 8'h82); wreg(0, 1, 8'h12);
        wreg(0, 0, 8'h83);
        rreg(0, 1, d); chk("R12 type readback", d, 8'hA8);
        wreg(0, 0, 8'h80);
        // configure slave: vector mode, id 3
        wreg(1, 0, 8'h58);
        wreg(1, 0, 8'h83); wreg(1, 1, 8'h50);
        wreg(1, 0, 8'h80); wreg(1, 1, 8'h00);
        // R2 priority among levels 2 and 5
        mreq = 8'h24; settle(2);
        chk("R2 irq", m_irq, 1);
        ack_exp("R6 dummy pulse", 0, 8'h00);
        ack_exp("R2 type level2", 1, 8'hAA);
        rreg(0, 0, d); chk("R7 isr set", d, 8'h04);
        chk("R4 equal blocked", m_irq, 0);
        // R4 nesting
        mreq = 8'h26; settle(2);
        chk("R4 higher nests", m_irq, 1);
        ack_exp("R6 dummy pulse", 0, 8'h00);
        ack_exp("R4 type level1", 1, 8'hA9);
        rreg(0, 0, d); chk("R7 nested isr", d, 8'h06);
        wreg(0, 0, 8'h00);
        rreg(0, 0, d); chk("R7 eoi highest", d, 8'h04);
        mreq = 8'h24; settle(2);
        chk("R4 equal level waits", m_irq, 0);
        wreg(0, 0, 8'h00);
        rreg(0, 0, d); chk("R7 eoi clear", d, 8'h00);
        chk("R7 irq after eoi", m_irq, 1);
        mreq = 8'h00; settle(2);
        chk("R2 irq drop", m_irq, 0);
        // R3 masking one line
        wreg(0, 1, 8'h04);
        mreq = 8'h04; settle(2);
        chk("R3 masked quiet", m_irq, 0);
        mreq = 8'h14; settle(2);
        chk("R3 other line", m_irq, 1);
        ack_exp("R6 dummy pulse", 0, 8'h00);
        ack_exp("R3 type level4", 1, 8'hAC);
        wreg(0, 0, 8'h00);
        mreq = 8'h00; wreg(0, 1, 8'h00); settle(2);
        // R10 spurious in vector mode
        chk("R10 no irq", m_irq, 0);
        ack_exp("R10 pulse1", 0, 8'h00);
        ack_exp("R10 type level7", 1, 8'hAF);
        chk("R10 cas idle", m_cas_oe, 0);
        rreg(0, 0, d); chk("R10 no isr", d, 8'h00);
        // R8 cascade to slave level 6
        sreq = 8'h40; settle(3);
        chk("R8 master irq", m_irq, 1);
        ack_exp("R8 pulse1", 0, 8'h00);
        chk("R8 cas_oe", m_cas_oe, 1);
        chk("R8 cas id", m_cas, 3);
        ack_exp("R9 slave type", 1, 8'h56);
        chk("R8 cas release", m_cas_oe, 0);
        rreg(0, 0, d); chk("R7 master isr", d, 8'h08);
        rreg(1, 0, d); chk("R9 slave isr", d, 8'h40);
        sreq = 8'h00;
        wreg(1, 0, 8'h00); wreg(0, 0, 8'h00);
        // R9 slave stays off bus when not selected
        sreq = 8'h01; mreq = 8'h01; settle(3);
        ack_exp("R6 dummy pulse", 0, 8'h00);
        ack_exp("R9 master owns bus", 1, 8'hA8);
        rreg(1, 0, d); chk("R9 slave isr untouched", d, 8'h00);
        sreq = 8'h00; mreq = 8'h00;
        wreg(0, 0, 8'h00); settle(2);
        // call mode on both
        wreg(0, 0, 8'h47);
        wreg(1, 0, 8'h59);
        wreg(1, 0, 8'h81); wreg(1, 1, 8'h80);
        wreg(1, 0, 8'h82); wreg(1, 1, 8'h34);
        mreq = 8'h40; settle(2);
        ack_exp("R5 opcode", 1, 8'hCD);
        ack_exp("R5 low byte", 1, 8'h58);
        ack_exp("R5 high byte", 1, 8'h12);
        wreg(0, 0, 8'h00);
        mreq = 8'h00;
        sreq = 8'h02; settle(3);
        ack_exp("R5 opcode cascade", 1, 8'hCD);
        chk("R8 call cas id", m_cas, 3);
        ack_exp("R9 slave low", 1, 8'h84);
        ack_exp("R9 slave high", 1, 8'h34);
        chk("R8 call cas release", m_cas_oe, 0);
        rreg(1, 0, d); chk("R9 slave call isr", d, 8'h02);
        sreq = 8'h00;
        wreg(1, 0, 8'h00); wreg(0, 0, 8'h00); settle(3);
        // R10 spurious in call mode
        ack_exp("R10 opcode", 1, 8'hCD);
        ack_exp("R10 low level7", 1, 8'h5C);
        ack_exp("R10 high", 1, 8'h12);
        settle(2);
        chk("R6 queue drained", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule